// File: doc/BRIEF.md
# Memory Power-Mode Controller

This block decides, cycle by cycle, which memory arrays of a chip are powered. It covers a nonvolatile array, an SRAM array and a programmable logic array. Software writes a small mode register to select two policies. One policy is whether the nonvolatile array may drop to standby whenever it is not addressed. The other is whether the logic array may fall into a zero-power idle state when its inputs stop moving.

From the chip-select, the per-array select decodes, the bus-width flag and the low address bit, the block drives an enable for each array and a separate enable for its even and odd halves. With the low-power policy on, a byte-wide bus powers only the half that the address selects. An activity timer watches the logic array's inputs. With turbo disabled, it flags zero-power idle after a stretch with no change. It also holds the output-valid flag low for one wake-up cycle after each input change.

Top module: `mpc_power_ctrl`

## Requirements
- R1: The mode register is written through `cfg_wr`/`cfg_wdata`, and the new value appears on the next rising edge. Bit 3 is the low-power bit and bit 4 is the turbo-disable bit. `cfg_rdata` returns those two bits in the same positions and 0 in all other bits. Both bits reset to 0.
- R2: While `cs_n` is 1, `nv_en`, `sram_en`, `nv_half` and `sram_half` are all 0, whatever the selects and the mode.
- R3: With the low-power bit 0 and `cs_n` 0, `nv_en` is 1 whether or not `nv_sel` is set.
- R4: With `cs_n` 0, `sram_en` equals `sram_sel`. With the low-power bit 1 and `cs_n` 0, `nv_en` equals `nv_sel`, so the nonvolatile array is off while only the SRAM is addressed.
- R5: With the low-power bit 1 and `byte_mode` 1, an enabled array has exactly one half on. Bit 0 of the half vector is the even half and is on when `addr_lsb` is 0. Bit 1 is the odd half and is on when `addr_lsb` is 1.
- R6: With `byte_mode` 0, or with the low-power bit 0, each half vector is 2'b11 whenever its array is enabled.
- R7: With the turbo-disable bit 0, `plc_zero_pwr` stays 0 however long `logic_in` is stable.
- R8: With the turbo-disable bit 1, `plc_zero_pwr` rises on the (IDLE_CYCLES+1)-th rising edge after a change is applied to `logic_in`. A further change restarts the count. If the inputs have already been stable that long, the flag rises on the edge that writes the bit.
- R9: With turbo disabled, the first edge that samples a `logic_in` change clears `plc_zero_pwr` and drops `plc_out_valid` for exactly one cycle. With turbo enabled, `plc_out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | CFG_W | Mode register write data |
| cfg_rdata | output | CFG_W | Mode register read data |
| cs_n | input | 1 | Chip select, active low |
| nv_sel | input | 1 | Nonvolatile array address decode |
| sram_sel | input | 1 | SRAM address decode |
| byte_mode | input | 1 | 1 = 8-bit data bus, 0 = 16-bit |
| addr_lsb | input | 1 | Address bit 0, selects the odd half in byte mode |
| logic_in | input | LOGIC_IN_W | Inputs of the logic array watched for activity |
| nv_en | output | 1 | Nonvolatile array enable |
| nv_half | output | 2 | Nonvolatile half enables {odd, even} |
| sram_en | output | 1 | SRAM enable |
| sram_half | output | 2 | SRAM half enables {odd, even} |
| plc_zero_pwr | output | 1 | Logic array in zero-power idle |
| plc_out_valid | output | 1 | Logic array output valid (0 during wake-up cycle) |

## Verification
The properties assume that every input, `logic_in` included, changes only between clock edges and is steady at each rising edge. They also assume that `cs_n`, the selects, `byte_mode` and `addr_lsb` carry no meaning until reset has been released. The stimulus changes every input on the falling edge and keeps reset asserted with all inputs at rest. It then waits for the internal synchroniser to release before writing the mode register.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int unsigned LOW_PWR_BIT   = 3;
  localparam int unsigned TURBO_OFF_BIT = 4;
  localparam int unsigned N_ARRAYS      = 2;
  localparam int unsigned ARR_NV        = 0;
  localparam int unsigned ARR_SRAM      = 1;

  typedef struct packed {
    logic turbo_off;
    logic low_pwr;
  } mode_t;

  typedef struct packed {
    logic       en;
    logic [1:0] half;
  } arr_ctl_t;
endpackage

// File: rtl/mpc_rst_sync.sv
module mpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/mpc_mode_reg.sv
module mpc_mode_reg
  import mpc_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output mode_t            mode,
  output logic [CFG_W-1:0] rdata
);
  mode_t mode_q;
  mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d.low_pwr   = wdata[LOW_PWR_BIT];
      mode_d.turbo_off = wdata[TURBO_OFF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= mode_d;
  end

  always_comb begin
    rdata                = '0;
    rdata[LOW_PWR_BIT]   = mode_q.low_pwr;
    rdata[TURBO_OFF_BIT] = mode_q.turbo_off;
  end

  assign mode = mode_q;
endmodule

// File: rtl/mpc_array_gate.sv
module mpc_array_gate
  import mpc_pkg::*;
#(
  parameter bit HOLD_WHEN_CS = 1'b1
) (
  input  logic     cs_n,
  input  logic     sel,
  input  logic     low_pwr,
  input  logic     byte_mode,
  input  logic     addr_lsb,
  output arr_ctl_t ctl
);
  logic hold_on;
  logic split;

  always_comb begin
    hold_on     = HOLD_WHEN_CS && !low_pwr;
    split       = low_pwr && byte_mode;
    ctl.en      = !cs_n && (sel || hold_on);
    ctl.half[0] = ctl.en && (!split || !addr_lsb);
    ctl.half[1] = ctl.en && (!split ||  addr_lsb);
  end
endmodule

// File: rtl/mpc_idle_timer.sv
module mpc_idle_timer #(
  parameter int unsigned IN_W        = 8,
  parameter int unsigned IDLE_CYCLES = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] sense,
  input  logic            turbo_off,
  output logic            zero_pwr,
  output logic            out_valid
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  logic [IN_W-1:0]  sense_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wake_q, wake_d;
  logic             moved;
  logic             cnt_en;

  always_comb begin
    moved  = (sense != sense_q);
    cnt_en = moved || (cnt_q != CNT_MAX);
    cnt_d  = moved ? '0 : cnt_q + 1'b1;
    wake_d = moved && turbo_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      cnt_q   <= '0;
      wake_q  <= 1'b0;
    end else begin
      sense_q <= sense;
      wake_q  <= wake_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign zero_pwr  = turbo_off && (cnt_q == CNT_MAX);
  assign out_valid = !wake_q;
endmodule

// File: rtl/mpc_power_ctrl.sv
module mpc_power_ctrl
  import mpc_pkg::*;
#(
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned LOGIC_IN_W  = 8,
  parameter int unsigned IDLE_CYCLES = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [CFG_W-1:0]      cfg_rdata,
  input  logic                  cs_n,
  input  logic                  nv_sel,
  input  logic                  sram_sel,
  input  logic                  byte_mode,
  input  logic                  addr_lsb,
  input  logic [LOGIC_IN_W-1:0] logic_in,
  output logic                  nv_en,
  output logic [1:0]            nv_half,
  output logic                  sram_en,
  output logic [1:0]            sram_half,
  output logic                  plc_zero_pwr,
  output logic                  plc_out_valid
);
  logic     rst_n_i;
  mode_t    mode;
  logic     sel_w [N_ARRAYS];
  arr_ctl_t ctl_w [N_ARRAYS];

  mpc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  mpc_mode_reg #(.CFG_W(CFG_W)) u_mode (
    .clk(clk), .rst_n(rst_n_i), .wr_en(cfg_wr), .wdata(cfg_wdata),
    .mode(mode), .rdata(cfg_rdata)
  );

  assign sel_w[ARR_NV]   = nv_sel;
  assign sel_w[ARR_SRAM] = sram_sel;

  for (genvar g = 0; g < N_ARRAYS; g++) begin : g_arr
    mpc_array_gate #(.HOLD_WHEN_CS(g == ARR_NV)) u_gate (
      .cs_n(cs_n), .sel(sel_w[g]), .low_pwr(mode.low_pwr),
      .byte_mode(byte_mode), .addr_lsb(addr_lsb), .ctl(ctl_w[g])
    );
  end

  assign nv_en     = ctl_w[ARR_NV].en;
  assign nv_half   = ctl_w[ARR_NV].half;
  assign sram_en   = ctl_w[ARR_SRAM].en;
  assign sram_half = ctl_w[ARR_SRAM].half;

  mpc_idle_timer #(.IN_W(LOGIC_IN_W), .IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n_i), .sense(logic_in), .turbo_off(mode.turbo_off),
    .zero_pwr(plc_zero_pwr), .out_valid(plc_out_valid)
  );
endmodule

// File: rtl/mpc_power_ctrl_chk.sv
module mpc_power_ctrl_chk #(
  parameter int unsigned CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             cs_n,
  input logic             nv_sel,
  input logic             sram_sel,
  input logic             byte_mode,
  input logic             nv_en,
  input logic [1:0]       nv_half,
  input logic             sram_en,
  input logic [1:0]       sram_half,
  input logic             plc_zero_pwr,
  input logic             plc_out_valid
);
  localparam logic [CFG_W-1:0] USED = CFG_W'(8'h18);

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~USED) == '0);

  a_r2_cs_off: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!nv_en && !sram_en && nv_half == 2'b00 && sram_half == 2'b00));

  a_r3_always_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cfg_rdata[3]) |-> nv_en);

  a_r4_select_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cfg_rdata[3]) |-> (nv_en == nv_sel && sram_en == sram_sel));

  a_r5_nv_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] && byte_mode && nv_en) |-> ($countones(nv_half) == 1));

  a_r5_sram_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] && byte_mode && sram_en) |-> ($countones(sram_half) == 1));

  a_r7_turbo_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[4] |-> !plc_zero_pwr);

  a_r9_wake_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !plc_out_valid |-> !plc_zero_pwr);
endmodule

bind mpc_power_ctrl mpc_power_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .cs_n(cs_n),
  .nv_sel(nv_sel), .sram_sel(sram_sel), .byte_mode(byte_mode),
  .nv_en(nv_en), .nv_half(nv_half), .sram_en(sram_en), .sram_half(sram_half),
  .plc_zero_pwr(plc_zero_pwr), .plc_out_valid(plc_out_valid)
);

// File: tb/tb_mpc_power_ctrl.sv
module tb_mpc_power_ctrl;
  localparam int IDLE = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       cs_n, nv_sel, sram_sel, byte_mode, addr_lsb;
  logic [7:0] logic_in;
  logic       nv_en, sram_en, plc_zero_pwr, plc_out_valid;
  logic [1:0] nv_half, sram_half;

  always #4ns clk = ~clk;

  mpc_power_ctrl #(.CFG_W(8), .LOGIC_IN_W(8), .IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cs_n(cs_n), .nv_sel(nv_sel), .sram_sel(sram_sel),
    .byte_mode(byte_mode), .addr_lsb(addr_lsb), .logic_in(logic_in),
    .nv_en(nv_en), .nv_half(nv_half), .sram_en(sram_en), .sram_half(sram_half),
    .plc_zero_pwr(plc_zero_pwr), .plc_out_valid(plc_out_valid)
  );

  typedef enum int {S_RD, S_NVEN, S_NVH, S_SREN, S_SRH, S_ZERO, S_VALID} sig_e;
  typedef struct { string req; sig_e sig; int exp; } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  task automatic push(input string req, input sig_e s, input int e);
    item_t it;
    it.req = req; it.sig = s; it.exp = e;
    q.push_back(it);
  endtask

  function automatic int peek(input sig_e s);
    case (s)
      S_RD:    return int'(cfg_rdata);
      S_NVEN:  return int'(nv_en);
      S_NVH:   return int'(nv_half);
      S_SREN:  return int'(sram_en);
      S_SRH:   return int'(sram_half);
      S_ZERO:  return int'(plc_zero_pwr);
      default: return int'(plc_out_valid);
    endcase
  endfunction

  // monitor: compares queued expectations one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1ns;
      while (q.size() > 0) begin
        item_t it;
        int    act;
        it  = q.pop_front();
        act = peek(it.sig);
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s: actual %0d expected %0d", it.req, it.sig.name(), act, it.exp);
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] d);
    tick();
    cfg_wr = 1'b1; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic set_bus(input logic c, input logic nv, input logic sr,
                         input logic bm, input logic lsb);
    cs_n = c; nv_sel = nv; sram_sel = sr; byte_mode = bm; addr_lsb = lsb;
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; logic_in = '0;
    set_bus(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (12) tick();

    // reset state
    push("R1", S_RD, 0);
    push("R9", S_VALID, 1);
    push("R7", S_ZERO, 0);
    push("R2", S_NVEN, 0);

    // R1: only bits 4 and 3 exist
    write_cfg(8'hFF);
    push("R1", S_RD, 8'h18);
    push("R8", S_ZERO, 1);      // inputs stable since reset: idle at once
    write_cfg(8'h00);
    push("R1", S_RD, 0);
    push("R7", S_ZERO, 0);

    // R2: chip-select high overrides in both modes
    for (int lp = 0; lp < 2; lp++) begin
      write_cfg(lp ? 8'h08 : 8'h00);
      set_bus(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      push("R2", S_NVEN, 0); push("R2", S_SREN, 0);
      push("R2", S_NVH, 0);  push("R2", S_SRH, 0);
    end

    // R3/R6: low-power clear, SRAM access keeps nonvolatile array on
    write_cfg(8'h00);
    set_bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    push("R3", S_NVEN, 1); push("R6", S_NVH, 3);
    push("R4", S_SREN, 1); push("R6", S_SRH, 3);

    // R4: low-power set, cross-array access
    write_cfg(8'h08);
    set_bus(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    push("R4", S_NVEN, 0); push("R4", S_NVH, 0); push("R4", S_SREN, 1);
    tick();
    set_bus(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    push("R4", S_NVEN, 1); push("R4", S_SREN, 0); push("R6", S_NVH, 3);

    // R5: byte mode half selection
    tick();
    set_bus(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    push("R5", S_NVH, 1); push("R5", S_SRH, 1);
    tick();
    set_bus(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    push("R5", S_NVH, 2); push("R5", S_SRH, 2);
    tick();
    set_bus(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    push("R6", S_NVH, 3); push("R6", S_SRH, 3);

    // R7/R9: turbo on, long stable inputs, no wake-up cycle
    write_cfg(8'h00);
    logic_in = 8'h5A;
    tick();
    push("R9", S_VALID, 1);
    repeat (20) tick();
    push("R7", S_ZERO, 0);

    // R8/R9: turbo off, idle entry and wake-up timing
    write_cfg(8'h10);
    push("R8", S_ZERO, 1);
    logic_in = 8'hA5;
    tick();
    push("R9", S_VALID, 0); push("R9", S_ZERO, 0);
    tick();
    push("R9", S_VALID, 1);
    repeat (IDLE - 2) tick();
    push("R8", S_ZERO, 0);
    tick();
    push("R8", S_ZERO, 1);

    // R8: a change mid-count restarts the interval
    logic_in = 8'h01;
    repeat (4) tick();
    logic_in = 8'h03;
    repeat (IDLE) tick();
    push("R8", S_ZERO, 0);
    tick();
    push("R8", S_ZERO, 1);

    repeat (3) tick();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule